// File: doc/BRIEF.md
# Bus Error Syndrome Responder

This block decides whether a memory-mapped access should complete with a subordinate-error response or a normal one. Four syndrome flags arrive with each completed access. One flags a malformed or unrecognised transaction. One flags a corrupted read of the shared-interrupt state RAM. One flags a corrupted read of the private-interrupt state RAM. The last flags an access to the translation unit while it is powered down. A direction input tells the block whether the access is a write. An enable bit, taken from the uncorrectable-error field of the error control register, gates all error reporting.

A syndrome counts only for the directions it applies to. The malformed and powered-down conditions apply to both reads and writes. The two RAM corruption conditions apply to reads only. When more than one syndrome counts for the same access, a fixed priority selects the one that is reported. One clock after the access completes, the block presents a registered result. The result holds a response code, a syndrome code for the error record, and a single-cycle capture pulse. The bus port logic and the corruption detectors sit outside this block.

Top module: `bus_err_responder`

## Requirements
- R1: While rst_n is low, and on the first edge after it, all outputs read zero: resp_valid=0, resp_code=2'b00, syn_code=0, err_pulse=0.
- R2: When ctl_ue_en is 0, a completed access returns resp_code 2'b00 (OKAY) and syn_code 0 with err_pulse low, whatever the syndrome inputs are.
- R3: With the enable set, syn_malformed returns resp_code 2'b10 (SLVERR) on both reads and writes, with syn_code 1.
- R4: With the enable set, syn_unit_off returns SLVERR on both reads and writes, with syn_code 2.
- R5: With the enable set, syn_shared_bad returns SLVERR with syn_code 3 on a read. On a write (acc_is_write=1) it is ignored.
- R6: With the enable set, syn_priv_bad returns SLVERR with syn_code 4 on a read. On a write it is ignored.
- R7: When several syndromes count for one access, the reported code follows this priority: malformed (1) first, then unit off (2), then shared RAM (3), then private RAM (4).
- R8: The result of an access with acc_done high in cycle N appears on the outputs in cycle N+1, with resp_valid=1. If no counted syndrome is present, resp_code is OKAY and syn_code is 0.
- R9: err_pulse is high for exactly those result cycles whose resp_code is SLVERR.
- R10: In a cycle after acc_done was low, resp_valid, resp_code, syn_code and err_pulse are all zero, whatever the syndrome inputs were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_done | input | 1 | An access completes this cycle |
| acc_is_write | input | 1 | 1 for a write, 0 for a read |
| ctl_ue_en | input | 1 | Uncorrectable-error reporting enable |
| syn_malformed | input | 1 | Transaction malformed or unrecognised |
| syn_shared_bad | input | 1 | Shared-interrupt RAM read corrupted |
| syn_priv_bad | input | 1 | Private-interrupt RAM read corrupted |
| syn_unit_off | input | 1 | Translation unit accessed while powered down |
| resp_valid | output | 1 | Registered result is valid |
| resp_code | output | 2 | Response, 2'b00 OKAY or 2'b10 SLVERR |
| syn_code | output | 3 | Reported syndrome, 0 when none |
| err_pulse | output | 1 | One-cycle error capture strobe |

## Verification
Two functions can fall in the same cycle: direction filtering and priority selection. A write can carry RAM corruption flags together with a higher or lower priority syndrome. The bench drives every combination of the four flags under both directions and both enable values. An expected model written from the requirements judges each result, so a write must let the filtered RAM flags drop out before the priority is applied. Back-to-back completions that alternate between error and clean results check that the capture pulse tracks each access and does not stretch across cycles.

// File: rtl/bus_err_pkg.sv
package bus_err_pkg;
    localparam int NUM_SYN = 4;
    localparam int SYN_W   = $clog2(NUM_SYN + 1);

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } resp_e;

    // Index order is also priority order (lowest index wins); code = index + 1
    localparam int IDX_MALFORMED  = 0;
    localparam int IDX_UNIT_OFF   = 1;
    localparam int IDX_SHARED_RAM = 2;
    localparam int IDX_PRIV_RAM   = 3;

    // Which syndromes count on reads and on writes
    localparam logic [NUM_SYN-1:0] RD_APPLIES = 4'b1111;
    localparam logic [NUM_SYN-1:0] WR_APPLIES = 4'b0011;
endpackage

// File: rtl/err_dir_filter.sv
module err_dir_filter #(
    parameter int               N       = 4,
    parameter logic [N-1:0]     RD_MASK = '1,
    parameter logic [N-1:0]     WR_MASK = '1
) (
    input  logic [N-1:0] raw,
    input  logic         is_write,
    input  logic         enable,
    output logic [N-1:0] live
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign live[g] = enable & raw[g] & (is_write ? WR_MASK[g] : RD_MASK[g]);
    end
endmodule

// File: rtl/err_prio_pick.sv
module err_prio_pick #(
    parameter int N  = 4,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [CW-1:0] code
);
    logic [N:0]   taken;
    logic [N-1:0] grant;

    assign taken[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant[g]   = req[g] & ~taken[g];
        assign taken[g+1] = taken[g] | req[g];
    end
    assign hit = taken[N];

    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) code = code | CW'(i + 1);
        end
    end
endmodule

// File: rtl/bus_err_responder.sv
module bus_err_responder
    import bus_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_done,
    input  logic             acc_is_write,
    input  logic             ctl_ue_en,
    input  logic             syn_malformed,
    input  logic             syn_shared_bad,
    input  logic             syn_priv_bad,
    input  logic             syn_unit_off,
    output logic             resp_valid,
    output logic [1:0]       resp_code,
    output logic [SYN_W-1:0] syn_code,
    output logic             err_pulse
);
    typedef struct packed {
        logic             vld;
        logic [1:0]       resp;
        logic [SYN_W-1:0] syn;
        logic             pulse;
    } res_t;

    res_t st_d, st_q;

    logic [NUM_SYN-1:0] raw_syn, live_syn;
    logic               any_hit;
    logic [SYN_W-1:0]   pick_code;

    always_comb begin
        raw_syn                 = '0;
        raw_syn[IDX_MALFORMED]  = syn_malformed;
        raw_syn[IDX_UNIT_OFF]   = syn_unit_off;
        raw_syn[IDX_SHARED_RAM] = syn_shared_bad;
        raw_syn[IDX_PRIV_RAM]   = syn_priv_bad;
    end

    err_dir_filter #(
        .N       (NUM_SYN),
        .RD_MASK (RD_APPLIES),
        .WR_MASK (WR_APPLIES)
    ) u_filter (
        .raw      (raw_syn),
        .is_write (acc_is_write),
        .enable   (ctl_ue_en),
        .live     (live_syn)
    );

    err_prio_pick #(
        .N  (NUM_SYN),
        .CW (SYN_W)
    ) u_pick (
        .req  (live_syn),
        .hit  (any_hit),
        .code (pick_code)
    );

    always_comb begin
        st_d = '0;
        if (acc_done) begin
            st_d.vld = 1'b1;
            if (any_hit) begin
                st_d.resp  = RESP_SLVERR;
                st_d.syn   = pick_code;
                st_d.pulse = 1'b1;
            end else begin
                st_d.resp  = RESP_OKAY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_valid = st_q.vld;
    assign resp_code  = st_q.resp;
    assign syn_code   = st_q.syn;
    assign err_pulse  = st_q.pulse;

    a_r2_disabled_okay: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && !ctl_ue_en) |=> (resp_code == RESP_OKAY && syn_code == '0));

    a_r3_malformed_err: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && ctl_ue_en && syn_malformed) |=>
        (resp_code == RESP_SLVERR && syn_code == SYN_W'(1)));

    a_r5_write_ram_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && acc_is_write && !syn_malformed && !syn_unit_off) |=>
        (resp_code == RESP_OKAY && !err_pulse));

    a_r8_valid_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> resp_valid);

    a_r9_pulse_with_slverr: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse == (resp_code == RESP_SLVERR));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_done |=> (!resp_valid && resp_code == 2'b00 && syn_code == '0 && !err_pulse));
endmodule

// File: tb/tb_bus_err_responder.sv
module tb_bus_err_responder;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_done = 1'b0, acc_is_write = 1'b0, ctl_ue_en = 1'b0;
    logic       syn_malformed = 1'b0, syn_shared_bad = 1'b0;
    logic       syn_priv_bad = 1'b0, syn_unit_off = 1'b0;
    logic       resp_valid, err_pulse;
    logic [1:0] resp_code;
    logic [2:0] syn_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_err_responder dut (
        .clk(clk), .rst_n(rst_n), .acc_done(acc_done), .acc_is_write(acc_is_write),
        .ctl_ue_en(ctl_ue_en), .syn_malformed(syn_malformed),
        .syn_shared_bad(syn_shared_bad), .syn_priv_bad(syn_priv_bad),
        .syn_unit_off(syn_unit_off), .resp_valid(resp_valid), .resp_code(resp_code),
        .syn_code(syn_code), .err_pulse(err_pulse)
    );

    typedef struct {
        logic       vld;
        logic [1:0] resp;
        logic [2:0] syn;
        logic       pulse;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done_flag = 0;

    // Reference model written from the requirements
    function automatic exp_t model(bit dn, bit wr, bit en, bit mf, bit sh, bit pv, bit uo, string tag);
        exp_t e;
        e.vld = dn; e.resp = 2'b00; e.syn = 3'd0; e.pulse = 1'b0; e.tag = tag;
        if (dn && en) begin
            if (mf)              e.syn = 3'd1;
            else if (uo)         e.syn = 3'd2;
            else if (sh && !wr)  e.syn = 3'd3;
            else if (pv && !wr)  e.syn = 3'd4;
            if (e.syn != 0) begin e.resp = 2'b10; e.pulse = 1'b1; end
        end
        return e;
    endfunction

    task automatic drive(bit dn, bit wr, bit en, bit mf, bit sh, bit pv, bit uo, string tag);
        @(negedge clk);
        acc_done = dn; acc_is_write = wr; ctl_ue_en = en;
        syn_malformed = mf; syn_shared_bad = sh; syn_priv_bad = pv; syn_unit_off = uo;
        q.push_back(model(dn, wr, en, mf, sh, pv, uo, tag));
    endtask

    // Monitor: compare each result one edge after its stimulus
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (resp_valid !== e.vld || resp_code !== e.resp ||
                    syn_code !== e.syn || err_pulse !== e.pulse) begin
                    n_bad++;
                    $display("FAIL %s (pulse R9): got vld=%0b resp=%0b syn=%0d pulse=%0b exp vld=%0b resp=%0b syn=%0d pulse=%0b",
                             e.tag, resp_valid, resp_code, syn_code, err_pulse,
                             e.vld, e.resp, e.syn, e.pulse);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        // R1: reset with busy inputs
        acc_done = 1; ctl_ue_en = 1; syn_malformed = 1;
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (resp_valid !== 0 || resp_code !== 0 || syn_code !== 0 || err_pulse !== 0) begin
            n_bad++;
            $display("FAIL R1: got vld=%0b resp=%0b syn=%0d pulse=%0b exp all zero",
                     resp_valid, resp_code, syn_code, err_pulse);
        end
        @(negedge clk);
        acc_done = 0; syn_malformed = 0; ctl_ue_en = 0;
        rst_n = 1;
        drive(0, 0, 0, 0, 0, 0, 0, "R1");

        // Full sweep: enable x direction x all syndrome combinations
        for (int en = 0; en < 2; en++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int s = 0; s < 16; s++) begin
                    string t;
                    bit mf = s[0], uo = s[1], sh = s[2], pv = s[3];
                    if (en == 0)                    t = "R2";
                    else if ($countones(s) > 1)     t = "R7";
                    else if (mf)                    t = "R3";
                    else if (uo)                    t = "R4";
                    else if (sh)                    t = "R5";
                    else if (pv)                    t = "R6";
                    else                            t = "R8";
                    drive(1, wr[0], en[0], mf, sh, pv, uo, t);
                end
            end
        end

        // R10: idle cycles with syndromes asserted
        drive(0, 0, 1, 1, 1, 1, 1, "R10");
        drive(0, 1, 1, 0, 1, 0, 1, "R10");

        // R9: back-to-back alternating error / clean completions
        for (int k = 0; k < 6; k++) begin
            drive(1, 0, 1, 0, (k % 2 == 0), 0, 0, "R9");
        end
        drive(1, 1, 1, 0, 1, 1, 0, "R5");
        drive(1, 1, 1, 0, 0, 1, 0, "R6");
        drive(1, 0, 1, 0, 1, 1, 0, "R7");
        drive(1, 1, 1, 0, 1, 1, 1, "R4");
        drive(0, 0, 0, 0, 0, 0, 0, "R10");
        drive(0, 0, 0, 0, 0, 0, 0, "R10");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end
endmodule